// File: doc/BRIEF.md
# Serial configuration bit streamer

This block is the read side of a serial configuration memory that feeds a bitstream into a programmable logic device. The device being configured supplies the clock, and the block puts one stored bit on its serial output for every clock while its chip enable is low and its combined reset/output-enable pin is inactive. An internal bit counter walks a small array from address zero up to the last address. It then stops, and the block releases its output and pulls its cascade enable output low.

Several copies can be chained: the cascade output of one copy drives the chip enable of the next, so the chain delivers the contents of all arrays back to back. Which level of the reset/output-enable pin means "reset" is held in a stored setting. The serial output is modelled as a data bit plus a drive flag, so high-impedance periods can be seen directly. A ready flag models an open-drain line that is pulled low while the block is held in reset. A plain synchronous write port fills the array for test.

Top module: `cfg_bit_streamer`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the polarity setting returns to active-high, the bit counter returns to address 0, the end-of-array state is cleared and `ready_pd` becomes 1.
- R2: A rising edge with `cfg_wr` high stores `cfg_pol_hi`. With a stored 1, the block is in reset while `rop_pin` is 1. With a stored 0, it is in reset while `rop_pin` is 0.
- R3: While in reset, `dout_en` is 0, `dout` is 0 and `ceo_n` is 1, and each rising edge clears the counter to address 0.
- R4: While out of reset with `ce_n` low and the array not yet exhausted, `dout_en` is 1 and `dout` carries the stored bit at the current address. Every rising edge moves the counter up by one, so bit k is presented in the k-th clock period after enable.
- R5: While `ce_n` is high, the counter holds and `dout_en` is 0. Streaming resumes at the same bit when `ce_n` returns low.
- R6: The rising edge that consumes the last address (DEPTH-1) marks the array exhausted. From then on `dout_en` is 0, the counter does not wrap, and `ceo_n` is low while `ce_n` is low.
- R7: Once exhausted and while out of reset, `ceo_n` equals `ce_n`. Entering reset drives `ceo_n` to 1.
- R8: `ready_pd` (1 = line pulled low) is 1 after any rising edge at which the block is in reset, and 0 after a rising edge at which it is not.
- R9: A rising edge with `wr_en` high stores `wr_bit` at address `wr_addr`. With `wr_en` low, the array is unchanged.
- R10: In a chain where `ceo_n` of the first copy drives `ce_n` of the second, the serial stream is the first array (address 0 upward) followed at once by the second array. At most one copy drives at any time, and the second copy starts only after the first copy's `ceo_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock from the device being configured |
| rst_n | input | 1 | Synchronous active-low block reset |
| rop_pin | input | 1 | Reset/output-enable pin, polarity set by the stored setting |
| ce_n | input | 1 | Active-low chip enable |
| cfg_wr | input | 1 | Stores `cfg_pol_hi` as the reset polarity |
| cfg_pol_hi | input | 1 | 1: reset when `rop_pin` is high; 0: reset when it is low |
| wr_en | input | 1 | Array write strobe |
| wr_addr | input | AW | Array write address, AW = $clog2(DEPTH) |
| wr_bit | input | 1 | Array write data |
| dout | output | 1 | Serial data bit, 0 when not driven |
| dout_en | output | 1 | Serial data drive flag (0 = high impedance) |
| ceo_n | output | 1 | Active-low cascade enable for the next copy |
| ready_pd | output | 1 | Open-drain ready model: 1 pulls the line low |

## Verification
The assertions take for granted that `rst_n` is held low for at least one rising edge before any other input matters, and that `rop_pin`, `ce_n` and the write port change only away from the rising edge. The stepping and exhaustion properties also assume the counter sees `ce_n` as a clean level for a whole period. The bench meets these conditions by changing every input just after the falling edge. It samples one time unit later and feeds the second copy only from the first copy's cascade output. It steps through every address of two 16-bit arrays, with a pause in the middle of the stream, and exercises both polarities and both reset sources.

// File: rtl/cfgs_pkg.sv
// Shared types for the serial configuration bit streamer.
package cfgs_pkg;

    // Meaning of the reset/output-enable pin level.
    typedef enum logic {
        POL_ACT_LOW  = 1'b0,
        POL_ACT_HIGH = 1'b1
    } rst_pol_e;

endpackage

// File: rtl/cfgs_ctrl.sv
// Reset decode for the streamer.
// Holds the stored polarity of the reset/output-enable pin, turns the pin
// level into a reset request and registers the open-drain ready flag.
// Assumes rst_n is synchronous to clk and that rop_pin is stable at edges.
module cfgs_ctrl
    import cfgs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rop_pin,
    input  logic cfg_wr,
    input  logic cfg_pol_hi,
    output logic rst_act,
    output logic ready_pd
);

    rst_pol_e pol_q;

    // Stored polarity setting, defaults to active-high.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pol_q <= POL_ACT_HIGH;
        else if (cfg_wr)
            pol_q <= cfg_pol_hi ? POL_ACT_HIGH : POL_ACT_LOW;
    end

    // Pin level compared with the stored polarity.
    always_comb begin
        rst_act = (pol_q == POL_ACT_HIGH) ? rop_pin : !rop_pin;
    end

    // Ready pull-down follows the reset request one edge later.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ready_pd <= 1'b1;
        else
            ready_pd <= rst_act;
    end

    assert_pol_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> ((pol_q == POL_ACT_HIGH) == $past(cfg_pol_hi)));

    assert_ready_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |=> ready_pd);

    assert_ready_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_act |=> !ready_pd);

endmodule

// File: rtl/cfgs_addr_seq.sv
// Saturating bit-address counter with an end-of-array flag.
// Clears on block reset or on a reset request. Advances by one per edge
// while stepping is enabled. On the edge that consumes the last address it
// raises the exhausted flag and stops, without wrapping.
module cfgs_addr_seq #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH),
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step_en,
    output logic [AW-1:0] addr,
    output logic          exhausted
);

    // Counter and end flag update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            addr      <= '0;
            exhausted <= 1'b0;
        end else if (step_en && !exhausted) begin
            if (addr == LAST)
                exhausted <= 1'b1;
            else
                addr <= addr + 1'b1;
        end
    end

    assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0) && !exhausted);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !step_en) |=> $stable(addr) && $stable(exhausted));

    assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && step_en && !exhausted && addr != LAST) |=> (addr == $past(addr) + 1'b1));

    assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        exhausted |-> (addr == LAST));

endmodule

// File: rtl/cfgs_bit_store.sv
// Bit array with a synchronous single-bit write port and an asynchronous
// read of the addressed bit. Storage is not reset. Writes to addresses at or
// above DEPTH match no cell and are dropped.
module cfgs_bit_store #(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);

    logic [DEPTH-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        // One storage cell, written when its address is selected.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == AW'(g)))
                cells[g] <= wr_bit;
        end
    end

    // Read of the addressed cell.
    always_comb begin
        rd_bit = cells[rd_addr];
    end

    assert_write_R9: assert property (@(posedge clk)
        wr_en |=> (cells[$past(wr_addr)] == $past(wr_bit)));

endmodule

// File: rtl/cfg_bit_streamer.sv
// Serial configuration bit streamer, top level.
// Streams the stored bits one per clock while chip enable is low and the
// reset/output-enable pin is inactive. When the array is used up it drops
// its output and hands over to the next copy through ceo_n.
// Assumes the clock comes from the device being configured and that all
// inputs change away from the rising edge.
module cfg_bit_streamer
    import cfgs_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rop_pin,
    input  logic          ce_n,
    input  logic          cfg_wr,
    input  logic          cfg_pol_hi,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic          wr_bit,
    output logic          dout,
    output logic          dout_en,
    output logic          ceo_n,
    output logic          ready_pd
);

    logic          rst_act;
    logic [AW-1:0] addr;
    logic          exhausted;
    logic          rd_bit;

    cfgs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rop_pin    (rop_pin),
        .cfg_wr     (cfg_wr),
        .cfg_pol_hi (cfg_pol_hi),
        .rst_act    (rst_act),
        .ready_pd   (ready_pd)
    );

    cfgs_addr_seq #(.DEPTH(DEPTH)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (rst_act),
        .step_en   (!ce_n),
        .addr      (addr),
        .exhausted (exhausted)
    );

    cfgs_bit_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_bit  (wr_bit),
        .rd_addr (addr),
        .rd_bit  (rd_bit)
    );

    // Serial output drive: only while enabled, out of reset and bits remain.
    always_comb begin
        dout_en = !rst_act && !ce_n && !exhausted;
        dout    = dout_en & rd_bit;
    end

    // Cascade enable: low once exhausted, then tracks ce_n until reset.
    always_comb begin
        ceo_n = (exhausted && !rst_act) ? ce_n : 1'b1;
    end

    assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ceo_n |-> !dout_en);

    assert_ceo_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_act |-> ceo_n);

    // Undriven output reads as zero.
    always_comb begin
        assert_quiet_R3: assert (dout_en || !dout);
    end

endmodule

// File: tb/sim_cfg_bit_streamer.sv
module sim_cfg_bit_streamer;

    localparam int D  = 16;
    localparam int AW = $clog2(D);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rop_pin = 1'b1;
    logic          ce_n = 1'b1;
    logic          cfg_wr = 1'b0;
    logic          cfg_pol_hi = 1'b1;
    logic          wr_en0 = 1'b0;
    logic          wr_en1 = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic          wr_bit = 1'b0;
    logic          dout0, den0, ceo0, rdy0;
    logic          dout1, den1, ceo1, rdy1;
    int            checks = 0;
    int            errors = 0;
    bit            finished = 1'b0;

    always #10 clk = !clk;

    cfg_bit_streamer #(.DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .rop_pin(rop_pin), .ce_n(ce_n),
        .cfg_wr(cfg_wr), .cfg_pol_hi(cfg_pol_hi),
        .wr_en(wr_en0), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .dout(dout0), .dout_en(den0), .ceo_n(ceo0), .ready_pd(rdy0)
    );

    cfg_bit_streamer #(.DEPTH(D)) u1 (
        .clk(clk), .rst_n(rst_n), .rop_pin(rop_pin), .ce_n(ceo0),
        .cfg_wr(cfg_wr), .cfg_pol_hi(cfg_pol_hi),
        .wr_en(wr_en1), .wr_addr(wr_addr), .wr_bit(wr_bit),
        .dout(dout1), .dout_en(den1), .ceo_n(ceo1), .ready_pd(rdy1)
    );

    function automatic logic pat(input int dev, input int i);
        return logic'((((i * 11) + (dev * 5) + 3) >> 2) & 1);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        #1;
    endtask

    task automatic wr(input int dev, input int a, input logic b);
        wr_addr = AW'(a);
        wr_bit  = b;
        if (dev == 0) wr_en0 = 1'b1; else wr_en1 = 1'b1;
        cyc();
        wr_en0 = 1'b0;
        wr_en1 = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: block reset with pin high
        cyc(); cyc();
        chk("R1", "ready_pd in block reset", int'(rdy0), 1);
        chk("R1", "dout_en in block reset", int'(den0), 0);
        chk("R3", "ceo_n in block reset", int'(ceo0), 1);
        rst_n = 1'b1;
        for (int i = 0; i < D; i++) begin
            wr(0, i, pat(0, i));
            wr(1, i, pat(1, i));
        end
        chk("R3", "dout_en pin high, active-high", int'(den0), 0);
        chk("R3", "dout while reset", int'(dout0), 0);
        chk("R8", "ready_pd while reset", int'(rdy0), 1);
        // release reset, keep chip enable high
        rop_pin = 1'b0;
        #1;
        chk("R8", "ready_pd before edge", int'(rdy0), 1);
        cyc();
        chk("R8", "ready_pd released", int'(rdy0), 0);
        cyc(); cyc();
        chk("R5", "dout_en with ce_n high", int'(den0), 0);
        chk("R5", "ceo_n with ce_n high", int'(ceo0), 1);
        // R10: full chained stream with a pause
        ce_n = 1'b0;
        for (int k = 0; k < 2 * D; k++) begin
            #1;
            chk("R10", "single driver", int'(den0) + int'(den1), 1);
            chk("R4", "stream bit", int'(den0 ? dout0 : dout1), int'((k < D) ? pat(0, k) : pat(1, k - D)));
            chk("R10", "first ceo_n", int'(ceo0), (k < D) ? 1 : 0);
            chk("R10", "second ceo_n", int'(ceo1), 1);
            if (k == 5) begin
                ce_n = 1'b1;
                for (int p = 0; p < 3; p++) begin
                    #1;
                    chk("R5", "paused dout_en", int'(den0 | den1), 0);
                    cyc();
                end
                ce_n = 1'b0;
                #1;
                chk("R5", "resume same bit", int'(dout0), int'(pat(0, 5)));
            end
            cyc();
        end
        #1;
        chk("R6", "no driver after end", int'(den0 | den1), 0);
        chk("R6", "second ceo_n low", int'(ceo1), 0);
        cyc(); cyc();
        chk("R6", "no wrap after end", int'(den0 | den1), 0);
        chk("R6", "first ceo_n stays low", int'(ceo0), 0);
        // R7: ceo_n follows ce_n, reset forces it high
        ce_n = 1'b1;
        #1;
        chk("R7", "first ceo_n follows high", int'(ceo0), 1);
        chk("R7", "second ceo_n follows high", int'(ceo1), 1);
        ce_n = 1'b0;
        #1;
        chk("R7", "first ceo_n follows low", int'(ceo0), 0);
        rop_pin = 1'b1;
        #1;
        chk("R7", "ceo_n high in reset", int'(ceo0), 1);
        chk("R3", "dout_en in reset", int'(den0), 0);
        cyc();
        chk("R8", "ready_pd after reset edge", int'(rdy0), 1);
        // R2: active-low polarity
        cfg_wr = 1'b1;
        cfg_pol_hi = 1'b0;
        cyc();
        cfg_wr = 1'b0;
        #1;
        chk("R2", "pin high active with low polarity", int'(den0), 1);
        chk("R3", "counter cleared by reset", int'(dout0), int'(pat(0, 0)));
        cyc();
        chk("R2", "second bit", int'(dout0), int'(pat(0, 1)));
        chk("R8", "ready released", int'(rdy0), 0);
        rop_pin = 1'b0;
        #1;
        chk("R2", "pin low is reset", int'(den0), 0);
        cyc();
        chk("R8", "ready_pd in low-pin reset", int'(rdy0), 1);
        // R9: write and suppressed write
        wr(0, 0, !pat(0, 0));
        wr_addr = AW'(1);
        wr_bit = !pat(0, 1);
        cyc();
        rop_pin = 1'b1;
        #1;
        chk("R9", "rewritten bit 0", int'(dout0), int'(!pat(0, 0)));
        cyc();
        chk("R9", "bit 1 untouched without wr_en", int'(dout0), int'(pat(0, 1)));
        // R1: block reset restores active-high polarity
        rst_n = 1'b0;
        cyc();
        chk("R1", "ready_pd in block reset", int'(rdy0), 1);
        rst_n = 1'b1;
        #1;
        chk("R1", "pin high is reset again", int'(den0), 0);
        rop_pin = 1'b0;
        #1;
        chk("R1", "counter at address 0", int'(dout0), int'(!pat(0, 0)));
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule